// File: doc/BRIEF.md
# Equalization Change-Request Checker

This block sits on the receiving side of transmitter equalization fine-tuning on a serial link. The far end sends a change request, already decoded from a training set. The request is one of two kinds. A preset request names a 4-bit preset index. A coefficient request gives three 6-bit magnitudes: pre-cursor, cursor and post-cursor. The block tests the request against the local full-swing (FS) and low-frequency (LF) limits. If the request is legal, the block applies the new tap setting. Whatever the outcome, it echoes the request in its reply fields and raises a reject bit when the request is refused.

A preset request is first turned into tap magnitudes. The same three legality checks then apply to those magnitudes. A refused request leaves the applied taps exactly as they were. The reply fields and the applied taps change only in response to a request, and they hold their values between requests.

Top module: `eqReqCheck`

## Requirements
- R1: After reset the applied taps are pre=0, cursor=INIT_CUR (default 48), post=0. All reply fields are zero, and the reject bit is low.
- R2: A request is taken on a rising clock edge at which `reqValid` is high. Its reply and its applied-tap update appear after the following rising edge. Both then hold, unchanged, until a later request is taken.
- R3: The reply fields (`replyUsePreset`, `replyPreset`, `replyPre`, `replyCur`, `replyPost`) always equal the request fields, whether the request is accepted or refused.
- R4: A preset request with an index of 11 or more is refused.
- R5: A preset request (`reqUsePreset`=1) with index p in 0..9 maps to pre=round(FS*a/120) and post=round(FS*b/120), rounding half up, with cursor=FS-pre-post. The pairs (a,b) are: 0:(0,30) 1:(0,20) 2:(0,24) 3:(0,15) 4:(0,0) 5:(12,0) 6:(15,0) 7:(12,24) 8:(15,15) 9:(20,0). Index 10 maps to pre=0, post=floor((FS-LF)/2) (or 0 when FS<LF), and cursor=FS-post.
- R6: A coefficient request (`reqUsePreset`=0) is refused unless pre+cursor+post equals FS exactly.
- R7: A request, whether it is a coefficient request or a mapped preset, is refused unless cursor-pre-post is at least LF.
- R8: A request is refused if its pre-cursor magnitude times 4 exceeds FS. A pre-cursor of exactly floor(FS/4) is allowed.
- R9: An accepted request loads its tap values (from the request, or from the preset mapping) into the applied taps. A refused request leaves the applied taps unchanged.
- R10: Requests on consecutive cycles are each handled in turn. Each one's reply appears one cycle after the previous one's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqUsePreset | input | 1 | 1 = preset request, 0 = coefficient request |
| reqPreset | input | 4 | Requested preset index |
| reqPre | input | 6 | Requested pre-cursor magnitude |
| reqCur | input | 6 | Requested cursor magnitude |
| reqPost | input | 6 | Requested post-cursor magnitude |
| localFs | input | 6 | Local full-swing limit |
| localLf | input | 6 | Local low-frequency limit |
| appliedPre | output | 6 | Pre-cursor magnitude in use |
| appliedCur | output | 6 | Cursor magnitude in use |
| appliedPost | output | 6 | Post-cursor magnitude in use |
| replyUsePreset | output | 1 | Echoed request kind |
| replyPreset | output | 4 | Echoed preset index |
| replyPre | output | 6 | Echoed pre-cursor |
| replyCur | output | 6 | Echoed cursor |
| replyPost | output | 6 | Echoed post-cursor |
| replyReject | output | 1 | Set when the last request was refused |

## Verification
Two events can fall on the same clock edge: a second request being captured, and the first request being committed. The bench provokes this by driving two requests on adjacent cycles. The first is legal and the second is refused. The bench then samples the outputs on each of the two following cycles. The first sample must show the first request's echo, with the new taps applied and no reject. The second sample must show the second request's echo, with reject set and the first request's taps still in place.

// File: rtl/eqReqPkg.sv
package eqReqPkg;
  typedef struct packed {
    logic capture;
    logic commit;
  } eqStrobes_t;

  localparam int RATIO_DEN   = 120;
  localparam int LAST_PRESET = 10;

  // pre-cursor share of FS, in 1/120 units
  function automatic int preNum(input int p);
    case (p)
      5, 7:    return 12;
      6, 8:    return 15;
      9:       return 20;
      default: return 0;
    endcase
  endfunction

  // post-cursor share of FS, in 1/120 units
  function automatic int postNum(input int p);
    case (p)
      0:       return 30;
      1:       return 20;
      2, 7:    return 24;
      3, 8:    return 15;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/eqReqCtrl.sv
module eqReqCtrl
  import eqReqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output eqStrobes_t strobes
);
  logic pendReg;

  always_ff @(posedge clk) begin
    if (!rstN) pendReg <= 1'b0;
    else       pendReg <= reqValid;
  end

  always_comb begin
    strobes.capture = reqValid;
    strobes.commit  = pendReg;
  end
endmodule

// File: rtl/eqPresetMap.sv
module eqPresetMap
  import eqReqPkg::*;
#(
  parameter int COEF_W   = 6,
  parameter int PRESET_W = 4
) (
  input  logic [PRESET_W-1:0] preset,
  input  logic [COEF_W-1:0]   fs,
  input  logic [COEF_W-1:0]   lf,
  output logic [COEF_W-1:0]   mapPre,
  output logic [COEF_W-1:0]   mapCur,
  output logic [COEF_W-1:0]   mapPost,
  output logic                known
);
  localparam int PROD_W = COEF_W + 7;

  logic [PROD_W-1:0] prodPre, prodPost, divPre, divPost;

  always_comb begin
    prodPre  = PROD_W'(fs) * PROD_W'(preNum(int'(preset)))  + PROD_W'(RATIO_DEN / 2);
    prodPost = PROD_W'(fs) * PROD_W'(postNum(int'(preset))) + PROD_W'(RATIO_DEN / 2);
    divPre   = prodPre  / PROD_W'(RATIO_DEN);
    divPost  = prodPost / PROD_W'(RATIO_DEN);
    known    = int'(preset) <= LAST_PRESET;
    if (int'(preset) == LAST_PRESET) begin
      mapPre  = '0;
      mapPost = (fs >= lf) ? ((fs - lf) >> 1) : '0;
    end else begin
      mapPre  = divPre[COEF_W-1:0];
      mapPost = divPost[COEF_W-1:0];
    end
    mapCur = fs - mapPre - mapPost;
  end
endmodule

// File: rtl/eqReqDatapath.sv
module eqReqDatapath
  import eqReqPkg::*;
#(
  parameter int COEF_W   = 6,
  parameter int PRESET_W = 4,
  parameter int INIT_CUR = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  eqStrobes_t          strobes,
  input  logic                reqUsePreset,
  input  logic [PRESET_W-1:0] reqPreset,
  input  logic [COEF_W-1:0]   reqPre,
  input  logic [COEF_W-1:0]   reqCur,
  input  logic [COEF_W-1:0]   reqPost,
  input  logic [COEF_W-1:0]   localFs,
  input  logic [COEF_W-1:0]   localLf,
  output logic [COEF_W-1:0]   appliedPre,
  output logic [COEF_W-1:0]   appliedCur,
  output logic [COEF_W-1:0]   appliedPost,
  output logic                replyUsePreset,
  output logic [PRESET_W-1:0] replyPreset,
  output logic [COEF_W-1:0]   replyPre,
  output logic [COEF_W-1:0]   replyCur,
  output logic [COEF_W-1:0]   replyPost,
  output logic                replyReject
);
  localparam int SUM_W = COEF_W + 3;

  logic                heldUse;
  logic [PRESET_W-1:0] heldPreset;
  logic [COEF_W-1:0]   heldPre, heldCur, heldPost;
  logic [COEF_W-1:0]   mapPre, mapCur, mapPost;
  logic                mapKnown;
  logic [COEF_W-1:0]   candPre, candCur, candPost;
  logic [SUM_W-1:0]    sumAll, lowSide;
  logic                badSum, badLf, badShoot, illegal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldUse    <= 1'b0;
      heldPreset <= '0;
      heldPre    <= '0;
      heldCur    <= '0;
      heldPost   <= '0;
    end else if (strobes.capture) begin
      heldUse    <= reqUsePreset;
      heldPreset <= reqPreset;
      heldPre    <= reqPre;
      heldCur    <= reqCur;
      heldPost   <= reqPost;
    end
  end

  eqPresetMap #(.COEF_W(COEF_W), .PRESET_W(PRESET_W)) u_map (
    .preset (heldPreset),
    .fs     (localFs),
    .lf     (localLf),
    .mapPre (mapPre),
    .mapCur (mapCur),
    .mapPost(mapPost),
    .known  (mapKnown)
  );

  always_comb begin
    candPre  = heldUse ? mapPre  : heldPre;
    candCur  = heldUse ? mapCur  : heldCur;
    candPost = heldUse ? mapPost : heldPost;
    sumAll   = SUM_W'(candPre) + SUM_W'(candCur) + SUM_W'(candPost);
    lowSide  = SUM_W'(candPre) + SUM_W'(candPost) + SUM_W'(localLf);
    badSum   = sumAll != SUM_W'(localFs);
    badLf    = SUM_W'(candCur) < lowSide;
    badShoot = (SUM_W'(candPre) << 2) > SUM_W'(localFs);
    illegal  = (heldUse && !mapKnown) || badSum || badLf || badShoot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      appliedPre     <= '0;
      appliedCur     <= COEF_W'(INIT_CUR);
      appliedPost    <= '0;
      replyUsePreset <= 1'b0;
      replyPreset    <= '0;
      replyPre       <= '0;
      replyCur       <= '0;
      replyPost      <= '0;
      replyReject    <= 1'b0;
    end else if (strobes.commit) begin
      if (!illegal) begin
        appliedPre  <= candPre;
        appliedCur  <= candCur;
        appliedPost <= candPost;
      end
      replyUsePreset <= heldUse;
      replyPreset    <= heldPreset;
      replyPre       <= heldPre;
      replyCur       <= heldCur;
      replyPost      <= heldPost;
      replyReject    <= illegal;
    end
  end
endmodule

// File: rtl/eqReqCheck.sv
module eqReqCheck
  import eqReqPkg::*;
#(
  parameter int COEF_W   = 6,
  parameter int PRESET_W = 4,
  parameter int INIT_CUR = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqUsePreset,
  input  logic [PRESET_W-1:0] reqPreset,
  input  logic [COEF_W-1:0]   reqPre,
  input  logic [COEF_W-1:0]   reqCur,
  input  logic [COEF_W-1:0]   reqPost,
  input  logic [COEF_W-1:0]   localFs,
  input  logic [COEF_W-1:0]   localLf,
  output logic [COEF_W-1:0]   appliedPre,
  output logic [COEF_W-1:0]   appliedCur,
  output logic [COEF_W-1:0]   appliedPost,
  output logic                replyUsePreset,
  output logic [PRESET_W-1:0] replyPreset,
  output logic [COEF_W-1:0]   replyPre,
  output logic [COEF_W-1:0]   replyCur,
  output logic [COEF_W-1:0]   replyPost,
  output logic                replyReject
);
  eqStrobes_t strobes;

  eqReqCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strobes (strobes)
  );

  eqReqDatapath #(.COEF_W(COEF_W), .PRESET_W(PRESET_W), .INIT_CUR(INIT_CUR)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .reqUsePreset  (reqUsePreset),
    .reqPreset     (reqPreset),
    .reqPre        (reqPre),
    .reqCur        (reqCur),
    .reqPost       (reqPost),
    .localFs       (localFs),
    .localLf       (localLf),
    .appliedPre    (appliedPre),
    .appliedCur    (appliedCur),
    .appliedPost   (appliedPost),
    .replyUsePreset(replyUsePreset),
    .replyPreset   (replyPreset),
    .replyPre      (replyPre),
    .replyCur      (replyCur),
    .replyPost     (replyPost),
    .replyReject   (replyReject)
  );
endmodule

// File: rtl/eqReqCheck_chk.sv
module eqReqCheck_chk #(
  parameter int COEF_W   = 6,
  parameter int PRESET_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqUsePreset,
  input logic [PRESET_W-1:0] reqPreset,
  input logic [COEF_W-1:0]   reqPre,
  input logic [COEF_W-1:0]   reqCur,
  input logic [COEF_W-1:0]   reqPost,
  input logic [COEF_W-1:0]   localFs,
  input logic [COEF_W-1:0]   appliedPre,
  input logic [COEF_W-1:0]   appliedCur,
  input logic [COEF_W-1:0]   appliedPost,
  input logic [COEF_W-1:0]   replyPre,
  input logic [COEF_W-1:0]   replyCur,
  input logic [COEF_W-1:0]   replyPost,
  input logic                replyReject
);
  logic [1:0] upCnt;
  logic       warm;
  logic [COEF_W+2:0] reqSum;

  always_ff @(posedge clk) begin
    if (!rstN)           upCnt <= '0;
    else if (upCnt != 3) upCnt <= upCnt + 2'd1;
  end

  assign warm   = upCnt >= 2'd2;
  assign reqSum = (COEF_W+3)'(reqPre) + (COEF_W+3)'(reqCur) + (COEF_W+3)'(reqPost);

  AST_ECHO_COEF: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(reqValid, 2)) |->
      (replyPre == $past(reqPre, 2) && replyCur == $past(reqCur, 2) && replyPost == $past(reqPost, 2))); // R3

  AST_REJECT_KEEPS_TAPS: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(reqValid, 2) && replyReject) |->
      (appliedPre == $past(appliedPre) && appliedCur == $past(appliedCur) && appliedPost == $past(appliedPost))); // R9

  AST_RESERVED_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(reqValid, 2) && $past(reqUsePreset, 2) && $past(reqPreset, 2) > PRESET_W'(10)) |-> replyReject); // R4

  AST_BAD_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(reqValid, 2) && !$past(reqUsePreset, 2) && $past(reqSum, 2) != (COEF_W+3)'($past(localFs, 2)))
      |-> replyReject); // R6

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !reqValid && !$past(reqValid)) |=>
      ($stable(replyReject) && $stable(replyCur) && $stable(appliedCur) && $stable(appliedPre))); // R2
endmodule

bind eqReqCheck eqReqCheck_chk #(.COEF_W(COEF_W), .PRESET_W(PRESET_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqUsePreset(reqUsePreset),
  .reqPreset   (reqPreset),
  .reqPre      (reqPre),
  .reqCur      (reqCur),
  .reqPost     (reqPost),
  .localFs     (localFs),
  .appliedPre  (appliedPre),
  .appliedCur  (appliedCur),
  .appliedPost (appliedPost),
  .replyPre    (replyPre),
  .replyCur    (replyCur),
  .replyPost   (replyPost),
  .replyReject (replyReject)
);

// File: tb/sim_eqReqCheck.sv
module sim_eqReqCheck;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqUsePreset = 1'b0;
  logic [3:0] reqPreset = '0;
  logic [5:0] reqPre = '0, reqCur = '0, reqPost = '0;
  logic [5:0] localFs = 6'd48, localLf = 6'd10;
  logic [5:0] appliedPre, appliedCur, appliedPost;
  logic       replyUsePreset;
  logic [3:0] replyPreset;
  logic [5:0] replyPre, replyCur, replyPost;
  logic       replyReject;

  int total = 0;
  int bad = 0;
  int ePre = 0, eCur = 48, ePost = 0;
  bit eRej = 0;

  always #5 clk = ~clk;

  eqReqCheck u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected outcome derived from the requirement text
  task automatic model(input bit up, input int p, input int pr, input int cu, input int po);
    int a, b, cp, cc, cq, fs, lf;
    bit rej;
    fs = int'(localFs); lf = int'(localLf);
    rej = 0;
    if (up) begin
      case (p)
        0: begin a = 0;  b = 30; end
        1: begin a = 0;  b = 20; end
        2: begin a = 0;  b = 24; end
        3: begin a = 0;  b = 15; end
        5: begin a = 12; b = 0;  end
        6: begin a = 15; b = 0;  end
        7: begin a = 12; b = 24; end
        8: begin a = 15; b = 15; end
        9: begin a = 20; b = 0;  end
        default: begin a = 0; b = 0; end
      endcase
      cp = (fs * a + 60) / 120;
      cq = (fs * b + 60) / 120;
      if (p == 10) begin cp = 0; cq = (fs >= lf) ? (fs - lf) / 2 : 0; end
      cc = fs - cp - cq;
      if (p > 10) rej = 1;
    end else begin
      cp = pr; cc = cu; cq = po;
    end
    if (cp + cc + cq != fs) rej = 1;   // R6
    if (cc - cp - cq < lf) rej = 1;    // R7
    if (cp * 4 > fs) rej = 1;          // R8
    eRej = rej;
    if (!rej) begin ePre = cp; eCur = cc; ePost = cq; end
  endtask

  task automatic drive(input bit up, input int p, input int pr, input int cu, input int po);
    reqValid = 1'b1; reqUsePreset = up; reqPreset = 4'(p);
    reqPre = 6'(pr); reqCur = 6'(cu); reqPost = 6'(po);
  endtask

  task automatic checkOut(input string tag, input bit up, input int p, input int pr, input int cu, input int po);
    chk(replyReject == eRej, {tag, " reject"}, int'(replyReject), int'(eRej));
    chk(appliedPre == 6'(ePre), {tag, " appliedPre R9"}, int'(appliedPre), ePre);
    chk(appliedCur == 6'(eCur), {tag, " appliedCur R9"}, int'(appliedCur), eCur);
    chk(appliedPost == 6'(ePost), {tag, " appliedPost R9"}, int'(appliedPost), ePost);
    chk(replyUsePreset == up && replyPreset == 4'(p), {tag, " echo preset R3"}, int'(replyPreset), p);
    chk(replyPre == 6'(pr) && replyCur == 6'(cu) && replyPost == 6'(po),
        {tag, " echo coef R3"}, int'(replyCur), cu);
  endtask

  // single request: drive, let two edges pass, sample at negedge
  task automatic oneReq(input string tag, input bit up, input int p, input int pr, input int cu, input int po);
    @(negedge clk);
    drive(up, p, pr, cu, po);
    @(negedge clk);
    reqValid = 1'b0;
    model(up, p, pr, cu, po);
    @(negedge clk);
    checkOut(tag, up, p, pr, cu, po);
  endtask

  task automatic testReset();
    chk(appliedPre == 0 && appliedPost == 0, "R1 applied pre/post", int'(appliedPre), 0);
    chk(appliedCur == 6'd48, "R1 applied cursor", int'(appliedCur), 48);
    chk(!replyReject && replyCur == 0 && replyPreset == 0, "R1 reply cleared", int'(replyReject), 0);
  endtask

  task automatic testCoef();
    oneReq("R6 legal coef", 0, 0, 6, 36, 6);
    oneReq("R6 bad sum", 0, 0, 6, 30, 6);
    oneReq("R7 below LF", 0, 0, 12, 24, 12);
    oneReq("R7 at LF edge", 0, 0, 10, 29, 9);
    oneReq("R8 preshoot over", 0, 0, 13, 30, 5);
    oneReq("R8 preshoot edge", 0, 0, 12, 34, 2);
  endtask

  task automatic testPreset();
    oneReq("R5 preset 7", 1, 7, 1, 2, 3);
    chk(appliedPre == 5 && appliedCur == 33 && appliedPost == 10, "R5 preset 7 taps", int'(appliedCur), 33);
    oneReq("R5 preset 10", 1, 10, 0, 0, 0);
    chk(appliedPost == 19 && appliedCur == 29, "R5 preset 10 taps", int'(appliedPost), 19);
    oneReq("R4 preset 11", 1, 11, 6, 36, 6);
    oneReq("R4 preset 15", 1, 15, 0, 48, 0);
    oneReq("R5 preset 3", 1, 3, 0, 0, 0);
    localLf = 6'd30;
    oneReq("R7 preset 0 vs LF", 1, 0, 0, 0, 0);
    localLf = 6'd10;
    oneReq("R5 preset 0", 1, 0, 0, 0, 0);
  endtask

  task automatic testHold();
    int c0, r0;
    c0 = int'(appliedCur); r0 = int'(replyCur);
    reqPre = 6'd1; reqCur = 6'd2; reqPost = 6'd3; reqUsePreset = 1'b0;
    repeat (5) @(negedge clk);
    chk(int'(appliedCur) == c0 && int'(replyCur) == r0, "R2 hold without request", int'(replyCur), r0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    drive(0, 0, 8, 32, 8);
    @(negedge clk);
    drive(0, 0, 8, 30, 8);
    @(negedge clk);
    reqValid = 1'b0;
    model(0, 0, 8, 32, 8);
    checkOut("R10 first of pair", 0, 0, 8, 32, 8);
    model(0, 0, 8, 30, 8);
    @(negedge clk);
    checkOut("R10 second of pair", 0, 0, 8, 30, 8);
    chk(replyReject && appliedCur == 6'd32, "R10 second refused keeps first", int'(appliedCur), 32);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCoef();
    testPreset();
    testHold();
    testBackToBack();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule